// File: doc/BRIEF.md
# Receive Polarity Detect and Correct

This block decides whether the twisted-pair receive pair has been wired in reverse. It drives one control bit that tells the receive data path to invert what it receives. The same decision is also brought out as a status bit, and as the pulse polarity that the link-pulse receiver should accept. The inversion itself is done elsewhere, and so is the recognition of end delimiters. This block only keeps and updates the decision.

Two sources feed the decision. When the link enters the pass state, the link-pulse logic reports the polarity it saw on its last run of link pulses, and that polarity becomes the starting setting. After that, each frame that ends with a valid end delimiter reports the delimiter's polarity. While detection is armed, every such frame overrides the setting. When a required number of consecutive valid frames agree, the decision locks and detection stops. Only a link failure or a reset arms it again.

Top module: `rxpol_ctrl`

## Requirements
- R1: After reset, `rx_invert_o` is 0 (normal polarity) and `armed_o` is 1.
- R2: A one-cycle `link_pass_i` pulse sets `rx_invert_o` to `lp_pol_i` (1 = reversed) on the next clock edge. This happens whether the block is armed or locked.
- R3: `lp_accept_pol_o` always equals the current decision. The value 1 means only negative (reversed) link pulses are accepted, and 0 means only positive pulses are accepted.
- R4: While armed, the first frame end with `etd_valid_i`=1 sets `rx_invert_o` to `etd_pol_i` on the next edge, whatever the earlier setting was.
- R5: While armed, a valid frame whose polarity differs from the previous valid frame also sets `rx_invert_o` to the new polarity. The block stays armed in that case.
- R6: A frame end with `etd_valid_i`=0 changes neither `rx_invert_o` nor `armed_o`, and it does not break a run of agreeing frames.
- R7: When CONFIRM_FRAMES (default 2) consecutive valid frames report the same polarity, `armed_o` drops to 0. Later frame ends then have no effect on `rx_invert_o`.
- R8: `link_fail_i` sets `armed_o` to 1 on the next edge and clears the agreement history. It leaves `rx_invert_o` unchanged.
- R9: In a cycle where both are present, `link_fail_i` takes priority over `link_pass_i` and over a frame end, and `link_pass_i` takes priority over a frame end. An event that loses is discarded.
- R10: `pol_rev_o` is 1 exactly when the inverted configuration is in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_fail_i | input | 1 | Link-fail event (one cycle) |
| link_pass_i | input | 1 | Link-pass entry event (one cycle) |
| lp_pol_i | input | 1 | Polarity of recent link pulses, 1 = reversed |
| frame_end_i | input | 1 | End of a received frame (one cycle) |
| etd_valid_i | input | 1 | End delimiter of that frame was valid |
| etd_pol_i | input | 1 | End delimiter polarity, 1 = reversed |
| rx_invert_o | output | 1 | Invert control for the receive data path |
| pol_rev_o | output | 1 | Polarity-reversed status bit |
| lp_accept_pol_o | output | 1 | Link-pulse polarity to accept, 1 = negative |
| armed_o | output | 1 | 1 = detection armed, 0 = locked |

## Verification
The hardest situation to reach is one where the agreement history must be shown cleared. Checking the outputs alone cannot tell a cleared history from one that still holds a frame. The stimulus therefore sends one valid frame of some polarity, then a link failure, then one more frame of the same polarity. The block must stay armed after that frame, because a stale history would have locked it. A second sequence shows that a frame with an invalid delimiter, placed between two agreeing frames, does not prevent the lock. Same-cycle collisions of link fail, link pass and frame end are driven directly to exercise the priority order.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;

    typedef enum logic {
        POL_NORMAL   = 1'b0,
        POL_REVERSED = 1'b1
    } pol_e;

    typedef struct packed {
        pol_e pol;
    } dec_t;

endpackage

// File: rtl/rxpol_tracker.sv
module rxpol_tracker #(
    parameter int CONFIRM_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic ev_i,
    input  logic ev_pol_i,
    output logic armed_o,
    output logic take_o
);
    localparam int CW = $clog2(CONFIRM_FRAMES + 1);

    typedef struct packed {
        logic          armed;
        logic          last;
        logic [CW-1:0] cnt;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [CW-1:0] cnt_next;

    always_comb begin
        trk_d    = trk_q;
        take_o   = trk_q.armed & ev_i & ~clear_i;
        cnt_next = trk_q.cnt;
        if (clear_i) begin
            trk_d.armed = 1'b1;
            trk_d.last  = 1'b0;
            trk_d.cnt   = '0;
        end else if (take_o) begin
            if ((trk_q.cnt != '0) && (ev_pol_i == trk_q.last)) begin
                cnt_next = trk_q.cnt + CW'(1);
            end else begin
                cnt_next = CW'(1);
            end
            trk_d.cnt  = cnt_next;
            trk_d.last = ev_pol_i;
            if (cnt_next >= CW'(CONFIRM_FRAMES)) begin
                trk_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{armed: 1'b1, last: 1'b0, cnt: '0};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign armed_o = trk_q.armed;

endmodule

// File: rtl/rxpol_decision.sv
module rxpol_decision
    import rxpol_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fail_i,
    input  logic load_i,
    input  logic load_pol_i,
    input  logic take_i,
    input  logic take_pol_i,
    output logic invert_o
);
    dec_t dec_d, dec_q;

    always_comb begin
        dec_d = dec_q;
        if (fail_i) begin
            dec_d = dec_q;
        end else if (load_i) begin
            dec_d.pol = pol_e'(load_pol_i);
        end else if (take_i) begin
            dec_d.pol = pol_e'(take_pol_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '{pol: POL_NORMAL};
        end else begin
            dec_q <= dec_d;
        end
    end

    assign invert_o = (dec_q.pol == POL_REVERSED);

endmodule

// File: rtl/rxpol_ctrl.sv
module rxpol_ctrl #(
    parameter int CONFIRM_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_fail_i,
    input  logic link_pass_i,
    input  logic lp_pol_i,
    input  logic frame_end_i,
    input  logic etd_valid_i,
    input  logic etd_pol_i,
    output logic rx_invert_o,
    output logic pol_rev_o,
    output logic lp_accept_pol_o,
    output logic armed_o
);
    logic frame_ev;
    logic take;
    logic invert;

    // link pass outranks a frame end; link fail is handled in each submodule
    assign frame_ev = frame_end_i & etd_valid_i & ~link_pass_i;

    rxpol_tracker #(.CONFIRM_FRAMES(CONFIRM_FRAMES)) u_tracker (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (link_fail_i),
        .ev_i     (frame_ev),
        .ev_pol_i (etd_pol_i),
        .armed_o  (armed_o),
        .take_o   (take)
    );

    rxpol_decision u_decision (
        .clk        (clk),
        .rst_n      (rst_n),
        .fail_i     (link_fail_i),
        .load_i     (link_pass_i),
        .load_pol_i (lp_pol_i),
        .take_i     (take),
        .take_pol_i (etd_pol_i),
        .invert_o   (invert)
    );

    assign rx_invert_o     = invert;
    assign pol_rev_o       = invert;
    assign lp_accept_pol_o = invert;

endmodule

// File: rtl/rxpol_ctrl_chk.sv
module rxpol_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic link_fail_i,
    input logic link_pass_i,
    input logic lp_pol_i,
    input logic frame_end_i,
    input logic etd_valid_i,
    input logic etd_pol_i,
    input logic rx_invert_o,
    input logic pol_rev_o,
    input logic lp_accept_pol_o,
    input logic armed_o
);
    AST_PASS_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (link_pass_i && !link_fail_i) |=> (rx_invert_o == $past(lp_pol_i))); // R2

    AST_ARMED_FRAME_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && frame_end_i && etd_valid_i && !link_fail_i && !link_pass_i)
        |=> (rx_invert_o == $past(etd_pol_i))); // R4

    AST_INVALID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end_i && !etd_valid_i && !link_fail_i && !link_pass_i)
        |=> ($stable(rx_invert_o) && $stable(armed_o))); // R6

    AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_o && !link_fail_i && !link_pass_i) |=> ($stable(rx_invert_o) && !armed_o)); // R7

    AST_LOCK_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(armed_o) |-> $past(frame_end_i && etd_valid_i && !link_fail_i)); // R7

    AST_FAIL_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        link_fail_i |=> (armed_o && $stable(rx_invert_o))); // R8

    AST_STATUS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_rev_o == rx_invert_o) && (lp_accept_pol_o == rx_invert_o)); // R10
endmodule

bind rxpol_ctrl rxpol_ctrl_chk u_chk (.*);

// File: tb/rxpol_ctrl_bench.sv
module rxpol_ctrl_bench;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_fail_i = 1'b0, link_pass_i = 1'b0, lp_pol_i = 1'b0;
    logic frame_end_i = 1'b0, etd_valid_i = 1'b0, etd_pol_i = 1'b0;
    logic rx_invert_o, pol_rev_o, lp_accept_pol_o, armed_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxpol_ctrl u_rxpol_ctrl (.*);

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic inv, input logic arm);
        check({req, " invert"}, rx_invert_o, inv);
        check("R10 pol_rev", pol_rev_o, inv);
        check("R3 accept_pol", lp_accept_pol_o, inv);
        check({req, " armed"}, armed_o, arm);
    endtask

    // drive one cycle of events at the negedge, return at the following negedge
    task automatic step(input logic fail, input logic pass, input logic lpp,
                        input logic fe, input logic ev, input logic ep);
        link_fail_i = fail; link_pass_i = pass; lp_pol_i = lpp;
        frame_end_i = fe; etd_valid_i = ev; etd_pol_i = ep;
        @(negedge clk);
        link_fail_i = 0; link_pass_i = 0; lp_pol_i = 0;
        frame_end_i = 0; etd_valid_i = 0; etd_pol_i = 0;
    endtask

    task automatic frame(input logic valid, input logic pol);
        step(0, 0, 0, 1, valid, pol);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check_out("R1", 1'b0, 1'b1);
    endtask

    task automatic t_link_pass();
        do_reset();
        step(0, 1, 1, 0, 0, 0);
        check_out("R2", 1'b1, 1'b1);
        step(0, 1, 0, 0, 0, 0);
        check_out("R2", 1'b0, 1'b1);
    endtask

    task automatic t_first_and_disagree();
        do_reset();
        step(0, 1, 1, 0, 0, 0);
        frame(1, 0);
        check_out("R4", 1'b0, 1'b1);
        frame(1, 1);
        check_out("R5", 1'b1, 1'b1);
        frame(1, 0);
        check_out("R5", 1'b0, 1'b1);
    endtask

    task automatic t_invalid_and_lock();
        do_reset();
        frame(0, 1);
        check_out("R6", 1'b0, 1'b1);
        frame(1, 1);
        check_out("R4", 1'b1, 1'b1);
        frame(0, 0);
        check_out("R6", 1'b1, 1'b1);
        frame(1, 1);
        check_out("R7", 1'b1, 1'b0);
        frame(1, 0);
        check_out("R7", 1'b1, 1'b0);
        frame(1, 0);
        check_out("R7", 1'b1, 1'b0);
    endtask

    task automatic t_fail_rearm();
        do_reset();
        frame(1, 1);
        frame(1, 1);
        check_out("R7", 1'b1, 1'b0);
        step(1, 0, 0, 0, 0, 0);
        check_out("R8", 1'b1, 1'b1);
        frame(1, 0);
        check_out("R8", 1'b0, 1'b1);
        // history: one frame, then fail, then same polarity must not lock
        step(1, 0, 0, 0, 0, 0);
        frame(1, 0);
        check_out("R8 history cleared", 1'b0, 1'b1);
        frame(1, 0);
        check_out("R7", 1'b0, 1'b0);
    endtask

    task automatic t_priority();
        do_reset();
        step(1, 1, 1, 1, 1, 1);
        check_out("R9 fail wins", 1'b0, 1'b1);
        step(0, 1, 1, 1, 1, 0);
        check_out("R9 pass over frame", 1'b1, 1'b1);
        frame(1, 1);
        check_out("R9 dropped frame not counted", 1'b1, 1'b1);
        frame(1, 1);
        check_out("R7", 1'b1, 1'b0);
        step(0, 1, 0, 0, 0, 0);
        check_out("R2 while locked", 1'b0, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_link_pass();
        t_first_and_disagree();
        t_invalid_and_lock();
        t_fail_rearm();
        t_priority();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule